// File: doc/BRIEF.md
# CAN Interframe Space and Overload Controller

This block follows the quiet gap that separates one CAN frame from the next. The frame logic sends a pulse when a frame has finished. From that pulse the block counts the intermission bits on the sampled bus. Once the intermission has passed without incident, it reports the bus as idle. A dominant bit that arrives too early in the gap is illegal, and the block answers it with an overload frame. A dominant bit in the last intermission bit, or at any time during idle, is the start of a new frame. The block reports it with a one-cycle pulse.

The node can also hold off the next message when it is not ready. It does this by sending overload frames, but never more than a set number in a row. That count starts again only when a frame really begins. While the node sends its own overload flag, the block asks the transmitter for a dominant level. It then waits for the bus to go recessive, which may take a while if other nodes' flags overlap its own. It then counts the recessive delimiter and returns to the first intermission bit.

The inputs are sampled only in cycles where the bit strobe is high. In the bus bit, 0 means dominant and 1 means recessive.

Top module: `can_ifs_overload`

## Requirements
- R1: In reset and in the first cycle after it, busIdle is 1 and txDominant, sofPulse and overloadActive are 0.
- R2: frameEnd moves the block into intermission with busIdle 0. After 3 strobed recessive bits, busIdle becomes 1 and stays 1 while only recessive bits follow.
- R3: A dominant bit (rxBit 0) sampled at intermission bit 1 or bit 2 starts an overload flag. txDominant then holds 1 for exactly 6 bit strobes.
- R4: A dominant bit sampled at intermission bit 3 gives sofPulse for one cycle. No overload starts.
- R5: A dominant bit sampled while the bus is idle gives sofPulse for one cycle and clears busIdle.
- R6: After its own flag, the block waits as long as the bus stays dominant. The first recessive bit is delimiter bit 1. After 7 more recessive bits, the block is back at intermission bit 1. overloadActive is 1 through the flag, the wait and the delimiter.
- R7: If notReady is high when intermission bit 1 is sampled recessive, an overload starts. At most 2 such requested overloads run back to back. After that, the intermission ends in idle even if notReady stays high.
- R8: The requested-overload count returns to zero when a frame start is detected, so a later request is honoured again.
- R9: A dominant bit sampled inside the delimiter starts a new 6-bit overload flag.
- R10: frameEnd takes priority over any bit in the same cycle, and it restarts the intermission from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitStb | input | 1 | High for one cycle when rxBit holds a sampled bus bit |
| rxBit | input | 1 | Sampled bus level, 0 dominant, 1 recessive |
| frameEnd | input | 1 | One-cycle pulse at the end of any frame |
| notReady | input | 1 | Request to delay the next message |
| txDominant | output | 1 | Asks the transmitter to drive dominant (own overload flag) |
| sofPulse | output | 1 | One-cycle pulse when a frame start is detected |
| busIdle | output | 1 | Bus idle after a completed intermission |
| overloadActive | output | 1 | High during an overload flag, the wait and the delimiter |

## Verification
The intermission is tried with all-recessive bits, which separates a clean gap from one that never reaches idle. A dominant bit is placed at each of the three intermission positions and in idle, which tells an illegal dominant bit apart from a frame start. Overloads are tried with and without overlapping dominant bits from other nodes, and with a dominant bit inside the delimiter. These show whether the wait and the delimiter are counted from the right edge. A steady notReady through three intermissions, followed by a frame start and a new request, shows both the cap on requested overloads and the point where the count clears.

// File: rtl/can_ifs_pkg.sv
package can_ifs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INTER,
    ST_FLAG,
    ST_WAIT,
    ST_DELIM,
    ST_FRAME
  } ifsState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic reqInc;
    logic reqClr;
  } dpCtl_t;

endpackage

// File: rtl/can_ifs_dp.sv
module can_ifs_dp
  import can_ifs_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int REQ_W   = 2,
  parameter int OVL_MAX = 2,
  parameter int CNT_TOP = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  output logic [CNT_W-1:0] cnt,
  output logic [REQ_W-1:0] reqCnt
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.cntClr) begin
      cnt <= '0;
    end else if (ctl.cntInc) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqCnt <= '0;
    end else if (ctl.reqClr) begin
      reqCnt <= '0;
    end else if (ctl.reqInc) begin
      reqCnt <= reqCnt + REQ_W'(1);
    end
  end

  // R7
  req_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqCnt <= REQ_W'(OVL_MAX));

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(CNT_TOP));

endmodule

// File: rtl/can_ifs_ctrl.sv
module can_ifs_ctrl
  import can_ifs_pkg::*;
#(
  parameter int IFS_LEN   = 3,
  parameter int FLAG_LEN  = 6,
  parameter int DELIM_LEN = 8,
  parameter int OVL_MAX   = 2,
  parameter int CNT_W     = 4,
  parameter int REQ_W     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitStb,
  input  logic             rxBit,
  input  logic             frameEnd,
  input  logic             notReady,
  input  logic [CNT_W-1:0] cnt,
  input  logic [REQ_W-1:0] reqCnt,
  output dpCtl_t           ctl,
  output logic             txDominant,
  output logic             sofPulse,
  output logic             busIdle,
  output logic             overloadActive
);

  ifsState_t state, nextState;
  logic      sofNext;
  logic      lastIfs, lastFlag, lastDelim, reqAllowed;

  // cnt holds the bits already done in the current phase
  assign lastIfs    = (cnt == CNT_W'(IFS_LEN - 1));
  assign lastFlag   = (cnt == CNT_W'(FLAG_LEN - 1));
  assign lastDelim  = (cnt == CNT_W'(DELIM_LEN - 1));
  assign reqAllowed = notReady && (reqCnt < REQ_W'(OVL_MAX));

  always_comb begin
    nextState = state;
    ctl       = '0;
    sofNext   = 1'b0;
    if (frameEnd) begin
      nextState  = ST_INTER;
      ctl.cntClr = 1'b1;
    end else if (bitStb) begin
      unique case (state)
        ST_IDLE: begin
          if (!rxBit) begin
            nextState  = ST_FRAME;
            sofNext    = 1'b1;
            ctl.reqClr = 1'b1;
          end
        end
        ST_INTER: begin
          ctl.cntInc = 1'b1;
          if (!rxBit) begin
            ctl.cntClr = 1'b1;
            if (lastIfs) begin
              nextState  = ST_FRAME;
              sofNext    = 1'b1;
              ctl.reqClr = 1'b1;
            end else begin
              nextState = ST_FLAG;
            end
          end else if (cnt == '0 && reqAllowed) begin
            nextState  = ST_FLAG;
            ctl.cntClr = 1'b1;
            ctl.reqInc = 1'b1;
          end else if (lastIfs) begin
            nextState  = ST_IDLE;
            ctl.cntClr = 1'b1;
          end
        end
        ST_FLAG: begin
          ctl.cntInc = 1'b1;
          if (lastFlag) begin
            nextState  = ST_WAIT;
            ctl.cntClr = 1'b1;
          end
        end
        ST_WAIT: begin
          if (rxBit) begin
            nextState  = ST_DELIM;
            ctl.cntInc = 1'b1;
          end
        end
        ST_DELIM: begin
          if (!rxBit) begin
            nextState  = ST_FLAG;
            ctl.cntClr = 1'b1;
          end else if (lastDelim) begin
            nextState  = ST_INTER;
            ctl.cntClr = 1'b1;
          end else begin
            ctl.cntInc = 1'b1;
          end
        end
        ST_FRAME: ;
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      sofPulse <= 1'b0;
    end else begin
      state    <= nextState;
      sofPulse <= sofNext;
    end
  end

  assign txDominant     = (state == ST_FLAG);
  assign busIdle        = (state == ST_IDLE);
  assign overloadActive = (state == ST_FLAG) || (state == ST_WAIT) || (state == ST_DELIM);

  // R3
  flag_end_on_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txDominant) |-> ($past(bitStb) || $past(frameEnd)));

  // R5
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busIdle) |-> (sofPulse || $past(frameEnd)));

  // R4
  sof_no_ovl_chk: assert property (@(posedge clk) disable iff (!rstN)
    sofPulse |-> (!overloadActive && !txDominant));

  // R5
  sof_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    sofPulse |=> !sofPulse);

  // R6
  delim_after_recessive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DELIM && $past(state) == ST_WAIT) |-> $past(rxBit));

endmodule

// File: rtl/can_ifs_overload.sv
module can_ifs_overload
  import can_ifs_pkg::*;
#(
  parameter int IFS_LEN   = 3,
  parameter int FLAG_LEN  = 6,
  parameter int DELIM_LEN = 8,
  parameter int OVL_MAX   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitStb,
  input  logic rxBit,
  input  logic frameEnd,
  input  logic notReady,
  output logic txDominant,
  output logic sofPulse,
  output logic busIdle,
  output logic overloadActive
);

  localparam int LEN_A   = (IFS_LEN > FLAG_LEN) ? IFS_LEN : FLAG_LEN;
  localparam int CNT_TOP = (LEN_A > DELIM_LEN) ? LEN_A : DELIM_LEN;
  localparam int CNT_W   = $clog2(CNT_TOP + 1);
  localparam int REQ_W   = $clog2(OVL_MAX + 1);

  dpCtl_t           ctl;
  logic [CNT_W-1:0] cnt;
  logic [REQ_W-1:0] reqCnt;

  can_ifs_ctrl #(
    .IFS_LEN(IFS_LEN), .FLAG_LEN(FLAG_LEN), .DELIM_LEN(DELIM_LEN),
    .OVL_MAX(OVL_MAX), .CNT_W(CNT_W), .REQ_W(REQ_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .bitStb(bitStb), .rxBit(rxBit),
    .frameEnd(frameEnd), .notReady(notReady), .cnt(cnt), .reqCnt(reqCnt),
    .ctl(ctl), .txDominant(txDominant), .sofPulse(sofPulse),
    .busIdle(busIdle), .overloadActive(overloadActive)
  );

  can_ifs_dp #(
    .CNT_W(CNT_W), .REQ_W(REQ_W), .OVL_MAX(OVL_MAX), .CNT_TOP(CNT_TOP)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cnt(cnt), .reqCnt(reqCnt)
  );

endmodule

// File: tb/test_can_ifs_overload.sv
module test_can_ifs_overload;

  localparam int CLK_PERIOD = 10;
  localparam int P_IDLE = 0, P_INTER = 1, P_FLAG = 2, P_WAIT = 3, P_DELIM = 4, P_FRAME = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitStb = 1'b0;
  logic rxWant = 1'b1;
  logic frameEnd = 1'b0;
  logic notReady = 1'b0;
  logic rxBit;
  logic txDominant, sofPulse, busIdle, overloadActive;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string cur = "R1";
  bit running = 1'b0;

  // reference model state
  int mPh = P_IDLE;
  int mBits = 0;
  int mReqs = 0;
  bit mSof = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // wired bus: own dominant request overrides the other nodes' level
  assign rxBit = rxWant & ~txDominant;

  can_ifs_overload i_can_ifs_overload (
    .clk(clk), .rstN(rstN), .bitStb(bitStb), .rxBit(rxBit),
    .frameEnd(frameEnd), .notReady(notReady), .txDominant(txDominant),
    .sofPulse(sofPulse), .busIdle(busIdle), .overloadActive(overloadActive)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh = P_IDLE; mBits = 0; mReqs = 0; mSof = 1'b0;
    end else begin
      mSof = 1'b0;
      if (frameEnd) begin
        mPh = P_INTER; mBits = 0;
      end else if (bitStb) begin
        if (mPh == P_IDLE) begin
          if (!rxBit) begin mPh = P_FRAME; mSof = 1'b1; mReqs = 0; end
        end else if (mPh == P_INTER) begin
          mBits++;
          if (!rxBit && mBits == 3) begin mPh = P_FRAME; mSof = 1'b1; mReqs = 0; end
          else if (!rxBit) begin mPh = P_FLAG; mBits = 0; end
          else if (mBits == 1 && notReady && mReqs < 2) begin mReqs++; mPh = P_FLAG; mBits = 0; end
          else if (mBits == 3) begin mPh = P_IDLE; mBits = 0; end
        end else if (mPh == P_FLAG) begin
          mBits++;
          if (mBits == 6) begin mPh = P_WAIT; mBits = 0; end
        end else if (mPh == P_WAIT) begin
          if (rxBit) begin mPh = P_DELIM; mBits = 1; end
        end else if (mPh == P_DELIM) begin
          if (!rxBit) begin mPh = P_FLAG; mBits = 0; end
          else begin
            mBits++;
            if (mBits == 8) begin mPh = P_INTER; mBits = 0; end
          end
        end
      end
    end
  end

  task automatic chk(string what, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b at %0t", cur, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (running) begin
      chk("txDominant", txDominant, mPh == P_FLAG);
      chk("sofPulse", sofPulse, mSof);
      chk("busIdle", busIdle, mPh == P_IDLE);
      chk("overloadActive", overloadActive,
          mPh == P_FLAG || mPh == P_WAIT || mPh == P_DELIM);
    end
    if (cycles > 20000) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic sendBit(input logic want);
    rxWant = want;
    bitStb = 1'b1;
    @(negedge clk);
    bitStb = 1'b0;
    rxWant = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic endFrame();
    frameEnd = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0;
    @(negedge clk);
  endtask

  // own flag, extra dominant bits from others, then the full delimiter
  task automatic runOverload(input int extraDom);
    for (int i = 0; i < 6; i++) sendBit(1'b1);
    for (int i = 0; i < extraDom; i++) sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur = "R1";
    chk("busIdle in reset", busIdle, 1'b1);
    chk("txDominant in reset", txDominant, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("busIdle after reset", busIdle, 1'b1);
    chk("overloadActive after reset", overloadActive, 1'b0);
    running = 1'b1;

    cur = "R2";
    endFrame();
    chk("busIdle in intermission", busIdle, 1'b0);
    for (int i = 0; i < 5; i++) sendBit(1'b1);
    chk("busIdle after intermission", busIdle, 1'b1);

    cur = "R5";
    sendBit(1'b0);
    chk("busIdle after idle SOF", busIdle, 1'b0);

    cur = "R3";
    endFrame();
    sendBit(1'b0);
    cur = "R6";
    runOverload(2);
    for (int i = 0; i < 3; i++) sendBit(1'b1);
    chk("idle after overload", busIdle, 1'b1);

    cur = "R3";
    endFrame();
    sendBit(1'b1);
    sendBit(1'b0);
    runOverload(0);
    for (int i = 0; i < 3; i++) sendBit(1'b1);

    cur = "R4";
    endFrame();
    sendBit(1'b1);
    sendBit(1'b1);
    sendBit(1'b0);
    chk("no overload at bit 3", overloadActive, 1'b0);

    cur = "R7";
    endFrame();
    notReady = 1'b1;
    sendBit(1'b1);
    runOverload(0);
    sendBit(1'b1);
    runOverload(1);
    for (int i = 0; i < 3; i++) sendBit(1'b1);
    chk("idle after capped requests", busIdle, 1'b1);

    cur = "R8";
    sendBit(1'b0);
    endFrame();
    sendBit(1'b1);
    chk("request honoured after SOF", overloadActive, 1'b1);
    runOverload(0);
    notReady = 1'b0;
    for (int i = 0; i < 3; i++) sendBit(1'b1);

    cur = "R9";
    endFrame();
    sendBit(1'b0);
    for (int i = 0; i < 6; i++) sendBit(1'b1);
    for (int i = 0; i < 3; i++) sendBit(1'b1);
    sendBit(1'b0);
    chk("flag restarts in delimiter", txDominant, 1'b1);
    runOverload(0);
    for (int i = 0; i < 3; i++) sendBit(1'b1);

    cur = "R10";
    endFrame();
    sendBit(1'b0);
    sendBit(1'b1);
    rxWant = 1'b0;
    bitStb = 1'b1;
    frameEnd = 1'b1;
    @(negedge clk);
    bitStb = 1'b0;
    frameEnd = 1'b0;
    rxWant = 1'b1;
    chk("frameEnd wins", overloadActive, 1'b0);
    for (int i = 0; i < 3; i++) sendBit(1'b1);
    chk("idle after restart", busIdle, 1'b1);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule